// File: doc/BRIEF.md
# Atomic halfword bit-clear unit

This unit carries out one atomic read-modify-write on a 16-bit memory location. It takes a request that has already been decoded. The request carries the low halfword of the operand register, a destination register index, a base register index, the base register value, the stack-pointer value, an acquire bit, a release bit, the current exception level and a data-independent-timing flag. The unit reads the halfword at the chosen address. It clears every bit that is set in the operand, writes the result back, and returns the value it read so the pipeline can write it to a register.

The read and the write go out over a locked memory port. The lock stays asserted for the whole operation, so no other agent can access the location between the read and the write. Along with the access, the unit drives the attributes the memory system needs: the ordering attributes, tag checking, privilege and a constant-time request. These attributes are worked out once, when the request is accepted.

The unit raises two faults: a misaligned stack pointer and a misaligned halfword address. A faulting request never reaches memory. Completion is reported by a one-cycle done pulse.

Top module: `hbc_unit`

## Requirements
- R1: The value written back to memory equals the value read, ANDed with the bitwise inverse of `req_opnd`.
- R2: On completion without a fault, `done_wdata` carries the value read, zero-extended to 32 bits. `done_dst` carries the destination index. `done_we` is 1 when the destination index is not 31.
- R3: With destination index 31, `done_we` is 0, and the memory location is still updated.
- R4: During the access, `mem_acq` equals `req_acq` AND (destination index not 31), and `mem_rel` equals `req_rel`.
- R5: Base index 31 takes the address from `req_sp_val`, and a non-zero value in its low 4 bits raises `done_fault_sp`. Any other base index takes the address from `req_base_val`.
- R6: `mem_tag_chk` is 1 exactly when the base index is not 31.
- R7: `mem_priv` is 1 exactly when `req_el` is non-zero.
- R8: If address bit 0 is set, `done_fault_align` is raised. On any fault there is no read and no write to memory, `done_we` is 0 and `done_wdata` is 0.
- R9: `mem_lock` is high in every cycle that has a read or write request. It stays high from the read request until the write is granted.
- R10: `mem_addr` and all access attributes hold steady from the read request until the write is granted.
- R11: `req_ready` is 1 only when the unit is idle, and it is 1 after reset. `done` is a pulse lasting one cycle.
- R12: `mem_const_time` carries `req_dit`. The unit's own cycle count from acceptance to `done` does not depend on the operand or memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_opnd | input | 16 | Low halfword of the operand register |
| req_dst_idx | input | 5 | Destination register index (31 means no write-back) |
| req_base_idx | input | 5 | Base register index (31 selects the stack pointer) |
| req_base_val | input | 64 | Base register value |
| req_sp_val | input | 64 | Stack-pointer value |
| req_acq | input | 1 | Acquire bit of the request |
| req_rel | input | 1 | Release bit of the request |
| req_el | input | 2 | Current exception level |
| req_dit | input | 1 | Data-independent timing requested |
| mem_rd_req | output | 1 | Read request |
| mem_rd_gnt | input | 1 | Read request accepted |
| mem_rd_rvalid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data |
| mem_wr_req | output | 1 | Write request |
| mem_wr_gnt | input | 1 | Write request accepted |
| mem_wr_data | output | 16 | Write data |
| mem_addr | output | 64 | Byte address of the access |
| mem_lock | output | 1 | Location locked for the whole operation |
| mem_acq | output | 1 | Acquire ordering attribute |
| mem_rel | output | 1 | Release ordering attribute |
| mem_tag_chk | output | 1 | Tag check enabled |
| mem_priv | output | 1 | Privileged access |
| mem_const_time | output | 1 | Memory must respond in data-independent time |
| done | output | 1 | Operation complete (one-cycle pulse) |
| done_wdata | output | 32 | Old value for write-back, zero-extended |
| done_we | output | 1 | Register write-back enable |
| done_dst | output | 5 | Destination index of the write-back |
| done_fault_sp | output | 1 | Stack-pointer alignment fault |
| done_fault_align | output | 1 | Halfword alignment fault |

## Verification
The assertions check the following on every cycle:
- the lock covers each memory request and lasts until the write is granted;
- the address and attributes do not move while the lock is held;
- `done` is a one-cycle pulse and `req_ready` is withheld while the unit is busy;
- a faulting request never takes the lock, and a fault or a zero-register destination never enables write-back;
- acquire is never flagged when the destination is index 31.

Only the bench scenarios can show the rest:
- the cleared value actually lands in memory, which the bench confirms by reading it back through a second operation;
- the correct address source is chosen for each base index;
- each of the four acquire/release combinations comes out right;
- a faulting request leaves memory untouched;
- latency under the constant-time flag stays the same when the data changes.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

   typedef struct packed {
      logic acq;
      logic rel;
      logic tag_chk;
      logic priv;
      logic const_time;
   } hbc_attr_t;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_RD    = 3'd1,
      S_RWAIT = 3'd2,
      S_WR    = 3'd3,
      S_DONE  = 3'd4
   } hbc_state_t;

endpackage

// File: rtl/hbc_decode.sv
module hbc_decode
   import hbc_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter int IDX_W         = 5,
   parameter int EL_W          = 2,
   parameter int SP_ALIGN_LOG2 = 4,
   parameter int HW_W          = 16
) (
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [IDX_W-1:0]  base_idx,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] sp_val,
   input  logic              acq_bit,
   input  logic              rel_bit,
   input  logic [EL_W-1:0]   el,
   input  logic              dit,
   output logic [ADDR_W-1:0] addr,
   output hbc_attr_t         attr,
   output logic              fault_sp,
   output logic              fault_align
);

   localparam logic [IDX_W-1:0] ZR_IDX = {IDX_W{1'b1}};
   localparam int HW_LOG2 = $clog2(HW_W / 8);

   logic use_sp;
   logic dst_is_zr;

   assign use_sp    = (base_idx == ZR_IDX);
   assign dst_is_zr = (dst_idx == ZR_IDX);
   assign addr      = use_sp ? sp_val : base_val;

   always_comb begin
      attr            = '0;
      attr.acq        = acq_bit && !dst_is_zr;
      attr.rel        = rel_bit;
      attr.tag_chk    = !use_sp;
      attr.priv       = (el != '0);
      attr.const_time = dit;
   end

   generate
      if (SP_ALIGN_LOG2 == 0) begin : g_sp_nochk
         assign fault_sp = 1'b0;
      end else begin : g_sp_chk
         assign fault_sp = use_sp && (sp_val[SP_ALIGN_LOG2-1:0] != '0);
      end
   endgenerate

   generate
      if (HW_LOG2 == 0) begin : g_al_nochk
         assign fault_align = 1'b0;
      end else begin : g_al_chk
         assign fault_align = (addr[HW_LOG2-1:0] != '0);
      end
   endgenerate

endmodule

// File: rtl/hbc_seq.sv
module hbc_seq
   import hbc_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 5,
   parameter int HW_W   = 16,
   parameter int OUT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [HW_W-1:0]   opnd,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [ADDR_W-1:0] dec_addr,
   input  hbc_attr_t         dec_attr,
   input  logic              dec_fault_sp,
   input  logic              dec_fault_align,
   output logic              mem_rd_req,
   input  logic              mem_rd_gnt,
   input  logic              mem_rd_rvalid,
   input  logic [HW_W-1:0]   mem_rd_data,
   output logic              mem_wr_req,
   input  logic              mem_wr_gnt,
   output logic [HW_W-1:0]   mem_wr_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_lock,
   output hbc_attr_t         mem_attr,
   output logic              done,
   output logic [OUT_W-1:0]  done_wdata,
   output logic              done_we,
   output logic [IDX_W-1:0]  done_dst,
   output logic              done_fault_sp,
   output logic              done_fault_align
);

   localparam logic [IDX_W-1:0] ZR_IDX = {IDX_W{1'b1}};

   hbc_state_t        state;
   logic [ADDR_W-1:0] addr_q;
   hbc_attr_t         attr_q;
   logic [HW_W-1:0]   opnd_q;
   logic [HW_W-1:0]   old_q;
   logic [IDX_W-1:0]  dst_q;
   logic              fsp_q;
   logic              fal_q;
   logic              we_q;
   logic              accept;
   logic              any_fault;

   assign req_ready = (state == S_IDLE);
   assign accept    = req_valid && req_ready;
   assign any_fault = dec_fault_sp || dec_fault_align;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         addr_q <= '0;
         attr_q <= '0;
         opnd_q <= '0;
         old_q  <= '0;
         dst_q  <= '0;
         fsp_q  <= 1'b0;
         fal_q  <= 1'b0;
         we_q   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               addr_q <= dec_addr;
               attr_q <= dec_attr;
               opnd_q <= opnd;
               old_q  <= '0;
               dst_q  <= dst_idx;
               fsp_q  <= dec_fault_sp;
               fal_q  <= dec_fault_align;
               we_q   <= !any_fault && (dst_idx != ZR_IDX);
               state  <= any_fault ? S_DONE : S_RD;
            end
            S_RD:    if (mem_rd_gnt) state <= S_RWAIT;
            S_RWAIT: if (mem_rd_rvalid) begin
               old_q <= mem_rd_data;
               state <= S_WR;
            end
            S_WR:    if (mem_wr_gnt) state <= S_DONE;
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign mem_rd_req  = (state == S_RD);
   assign mem_wr_req  = (state == S_WR);
   assign mem_lock    = (state == S_RD) || (state == S_RWAIT) || (state == S_WR);
   assign mem_addr    = addr_q;
   assign mem_attr    = attr_q;
   assign mem_wr_data = old_q & ~opnd_q;

   assign done             = (state == S_DONE);
   assign done_wdata       = {{(OUT_W-HW_W){1'b0}}, old_q};
   assign done_we          = done && we_q;
   assign done_dst         = dst_q;
   assign done_fault_sp    = done && fsp_q;
   assign done_fault_align = done && fal_q;

   AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req || mem_wr_req) |-> mem_lock); // R9
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && !(mem_wr_req && mem_wr_gnt)) |=> mem_lock); // R9
   AST_ATTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && !(mem_wr_req && mem_wr_gnt)) |=> $stable({mem_attr, mem_addr})); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock || done) |-> !req_ready); // R11
   AST_FAULT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && any_fault) |=> (!mem_lock && done)); // R8
   AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (done_fault_sp || done_fault_align) |-> (!done_we && done_wdata == '0)); // R8
   AST_ZR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_dst == ZR_IDX) |-> !done_we); // R3
   AST_ZR_NO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && dst_q == ZR_IDX) |-> !mem_attr.acq); // R4

endmodule

// File: rtl/hbc_unit.sv
module hbc_unit
   import hbc_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter int IDX_W         = 5,
   parameter int EL_W          = 2,
   parameter int HW_W          = 16,
   parameter int OUT_W         = 32,
   parameter int SP_ALIGN_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [HW_W-1:0]   req_opnd,
   input  logic [IDX_W-1:0]  req_dst_idx,
   input  logic [IDX_W-1:0]  req_base_idx,
   input  logic [ADDR_W-1:0] req_base_val,
   input  logic [ADDR_W-1:0] req_sp_val,
   input  logic              req_acq,
   input  logic              req_rel,
   input  logic [EL_W-1:0]   req_el,
   input  logic              req_dit,
   output logic              mem_rd_req,
   input  logic              mem_rd_gnt,
   input  logic              mem_rd_rvalid,
   input  logic [HW_W-1:0]   mem_rd_data,
   output logic              mem_wr_req,
   input  logic              mem_wr_gnt,
   output logic [HW_W-1:0]   mem_wr_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_lock,
   output logic              mem_acq,
   output logic              mem_rel,
   output logic              mem_tag_chk,
   output logic              mem_priv,
   output logic              mem_const_time,
   output logic              done,
   output logic [OUT_W-1:0]  done_wdata,
   output logic              done_we,
   output logic [IDX_W-1:0]  done_dst,
   output logic              done_fault_sp,
   output logic              done_fault_align
);

   generate
      if (HW_W < 8 || (HW_W % 8) != 0) begin : g_bad_hw
         $error("hbc_unit: HW_W must be a whole number of bytes");
      end
      if (OUT_W < HW_W) begin : g_bad_out
         $error("hbc_unit: OUT_W must be at least HW_W");
      end
      if (SP_ALIGN_LOG2 < 0 || SP_ALIGN_LOG2 >= ADDR_W) begin : g_bad_sp
         $error("hbc_unit: SP_ALIGN_LOG2 out of range");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("hbc_unit: IDX_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0] dec_addr;
   hbc_attr_t         dec_attr;
   hbc_attr_t         mem_attr;
   logic              dec_fault_sp;
   logic              dec_fault_align;

   hbc_decode #(
      .ADDR_W        (ADDR_W),
      .IDX_W         (IDX_W),
      .EL_W          (EL_W),
      .SP_ALIGN_LOG2 (SP_ALIGN_LOG2),
      .HW_W          (HW_W)
   ) u_decode (
      .dst_idx     (req_dst_idx),
      .base_idx    (req_base_idx),
      .base_val    (req_base_val),
      .sp_val      (req_sp_val),
      .acq_bit     (req_acq),
      .rel_bit     (req_rel),
      .el          (req_el),
      .dit         (req_dit),
      .addr        (dec_addr),
      .attr        (dec_attr),
      .fault_sp    (dec_fault_sp),
      .fault_align (dec_fault_align)
   );

   hbc_seq #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .HW_W   (HW_W),
      .OUT_W  (OUT_W)
   ) u_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_valid        (req_valid),
      .req_ready        (req_ready),
      .opnd             (req_opnd),
      .dst_idx          (req_dst_idx),
      .dec_addr         (dec_addr),
      .dec_attr         (dec_attr),
      .dec_fault_sp     (dec_fault_sp),
      .dec_fault_align  (dec_fault_align),
      .mem_rd_req       (mem_rd_req),
      .mem_rd_gnt       (mem_rd_gnt),
      .mem_rd_rvalid    (mem_rd_rvalid),
      .mem_rd_data      (mem_rd_data),
      .mem_wr_req       (mem_wr_req),
      .mem_wr_gnt       (mem_wr_gnt),
      .mem_wr_data      (mem_wr_data),
      .mem_addr         (mem_addr),
      .mem_lock         (mem_lock),
      .mem_attr         (mem_attr),
      .done             (done),
      .done_wdata       (done_wdata),
      .done_we          (done_we),
      .done_dst         (done_dst),
      .done_fault_sp    (done_fault_sp),
      .done_fault_align (done_fault_align)
   );

   assign mem_acq        = mem_attr.acq;
   assign mem_rel        = mem_attr.rel;
   assign mem_tag_chk    = mem_attr.tag_chk;
   assign mem_priv       = mem_attr.priv;
   assign mem_const_time = mem_attr.const_time;

endmodule

// File: tb/hbc_unit_bench.sv
module hbc_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_opnd = '0;
   logic [4:0]  req_dst_idx = '0;
   logic [4:0]  req_base_idx = '0;
   logic [63:0] req_base_val = '0;
   logic [63:0] req_sp_val = '0;
   logic        req_acq = 1'b0;
   logic        req_rel = 1'b0;
   logic [1:0]  req_el = '0;
   logic        req_dit = 1'b0;
   logic        mem_rd_req, mem_rd_gnt, mem_rd_rvalid;
   logic [15:0] mem_rd_data;
   logic        mem_wr_req, mem_wr_gnt;
   logic [15:0] mem_wr_data;
   logic [63:0] mem_addr;
   logic        mem_lock, mem_acq, mem_rel, mem_tag_chk, mem_priv, mem_const_time;
   logic        done, done_we, done_fault_sp, done_fault_align;
   logic [31:0] done_wdata;
   logic [4:0]  done_dst;

   always #2 clk = ~clk;

   hbc_unit u_hbc_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_opnd(req_opnd), .req_dst_idx(req_dst_idx), .req_base_idx(req_base_idx),
      .req_base_val(req_base_val), .req_sp_val(req_sp_val), .req_acq(req_acq),
      .req_rel(req_rel), .req_el(req_el), .req_dit(req_dit),
      .mem_rd_req(mem_rd_req), .mem_rd_gnt(mem_rd_gnt), .mem_rd_rvalid(mem_rd_rvalid),
      .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_gnt(mem_wr_gnt),
      .mem_wr_data(mem_wr_data), .mem_addr(mem_addr), .mem_lock(mem_lock),
      .mem_acq(mem_acq), .mem_rel(mem_rel), .mem_tag_chk(mem_tag_chk),
      .mem_priv(mem_priv), .mem_const_time(mem_const_time), .done(done),
      .done_wdata(done_wdata), .done_we(done_we), .done_dst(done_dst),
      .done_fault_sp(done_fault_sp), .done_fault_align(done_fault_align)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int stall_from = 0;
   int stall_to = 0;
   int done_cnt = 0;
   int acc_cyc = 0;
   int last_lat = 0;
   bit seen_mem = 1'b0;

   typedef struct {
      logic [31:0] wdata;
      bit          we;
      bit          fsp;
      bit          fal;
      bit          acq;
      bit          rel;
      bit          tag;
      bit          priv;
      bit          ct;
      logic [63:0] addr;
      logic [4:0]  dst;
   } exp_t;
   exp_t q[$];

   logic [15:0] mem [128];
   logic [15:0] ref_mem [128];

   function automatic logic [15:0] init_val(int i);
      logic [15:0] v;
      v = 16'(i * 16'h1357) ^ 16'hC0DE;
      return v;
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: grants outside the stall window, read data one cycle after grant
   assign mem_rd_gnt = !(cyc >= stall_from && cyc < stall_to);
   assign mem_wr_gnt = mem_rd_gnt;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
         mem_rd_rvalid <= 1'b0;
         mem_rd_data   <= '0;
      end else begin
         mem_rd_rvalid <= mem_rd_req && mem_rd_gnt;
         mem_rd_data   <= mem[mem_addr[7:1]];
         if (mem_wr_req && mem_wr_gnt) mem[mem_addr[7:1]] <= mem_wr_data;
      end
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_req || mem_wr_req) begin
            seen_mem = 1'b1;
            chk(mem_lock, "R9 lock during request", 64'(mem_lock), 64'd1);
            chk(!req_ready, "R11 ready low while busy", 64'(req_ready), 64'd0);
            if (q.size() > 0) begin
               chk(mem_addr == q[0].addr, "R5 address source", mem_addr, q[0].addr);
               chk(mem_acq == q[0].acq && mem_rel == q[0].rel, "R4 ordering attrs",
                   64'({mem_acq, mem_rel}), 64'({q[0].acq, q[0].rel}));
               chk(mem_tag_chk == q[0].tag, "R6 tag check", 64'(mem_tag_chk), 64'(q[0].tag));
               chk(mem_priv == q[0].priv, "R7 privilege", 64'(mem_priv), 64'(q[0].priv));
               chk(mem_const_time == q[0].ct, "R12 const time attr",
                   64'(mem_const_time), 64'(q[0].ct));
            end
         end
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(done_wdata == e.wdata, "R2 write-back data", 64'(done_wdata), 64'(e.wdata));
               chk(done_we == e.we, "R3 write enable", 64'(done_we), 64'(e.we));
               chk(done_dst == e.dst, "R2 destination", 64'(done_dst), 64'(e.dst));
               chk(done_fault_sp == e.fsp && done_fault_align == e.fal, "R8 fault flags",
                   64'({done_fault_sp, done_fault_align}), 64'({e.fsp, e.fal}));
               if (e.fsp || e.fal)
                  chk(!seen_mem, "R8 no memory access on fault", 64'(seen_mem), 64'd0);
            end
            last_lat = cyc - acc_cyc;
            seen_mem = 1'b0;
            done_cnt++;
         end
      end
   end

   task automatic do_op(input logic [15:0] opnd, input logic [4:0] dst,
                        input logic [4:0] bidx, input logic [63:0] bval,
                        input logic [63:0] sp, input bit acq, input bit rel,
                        input logic [1:0] el, input bit dit, input int stall);
      exp_t e;
      logic [63:0] a;
      logic [15:0] old;
      int target;
      a       = (bidx == 5'd31) ? sp : bval;
      e.addr  = a;
      e.fsp   = (bidx == 5'd31) && (sp[3:0] != 4'd0);
      e.fal   = a[0];
      e.acq   = acq && (dst != 5'd31);
      e.rel   = rel;
      e.tag   = (bidx != 5'd31);
      e.priv  = (el != 2'd0);
      e.ct    = dit;
      e.dst   = dst;
      if (e.fsp || e.fal) begin
         e.wdata = '0;
         e.we    = 1'b0;
      end else begin
         old = ref_mem[a[7:1]];
         ref_mem[a[7:1]] = old & ~opnd;
         e.wdata = {16'd0, old};
         e.we    = (dst != 5'd31);
      end
      q.push_back(e);
      target = done_cnt + 1;
      @(negedge clk);
      req_opnd = opnd; req_dst_idx = dst; req_base_idx = bidx; req_base_val = bval;
      req_sp_val = sp; req_acq = acq; req_rel = rel; req_el = el; req_dit = dit;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      acc_cyc = cyc;
      stall_from = cyc;
      stall_to = cyc + stall;
      req_valid = 1'b0;
      while (done_cnt < target) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lat_a;
      for (int i = 0; i < 128; i++) ref_mem[i] = init_val(i);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(req_ready, "R11 ready after reset", 64'(req_ready), 64'd1);
      chk(!done && !mem_lock && !mem_rd_req && !mem_wr_req, "R11 quiet after reset",
          64'({done, mem_lock, mem_rd_req, mem_wr_req}), 64'd0);

      // R1 R2 plain, no ordering, base register
      do_op(16'h00F0, 5'd3, 5'd4, 64'h10, 64'h0, 0, 0, 2'd0, 0, 0);
      // R1 readback through the interface (operand 0 leaves memory unchanged)
      do_op(16'h0000, 5'd3, 5'd4, 64'h10, 64'h0, 0, 0, 2'd0, 0, 0);
      // R4 acquire only, release only
      do_op(16'h1234, 5'd7, 5'd2, 64'h22, 64'h0, 1, 0, 2'd2, 0, 0);
      do_op(16'h8001, 5'd8, 5'd2, 64'h24, 64'h0, 0, 1, 2'd0, 0, 0);
      // R3 R4 zero-register destination drops acquire, memory still updated
      do_op(16'hFF00, 5'd31, 5'd6, 64'h30, 64'h0, 1, 1, 2'd0, 0, 0);
      do_op(16'h0000, 5'd9, 5'd6, 64'h30, 64'h0, 1, 1, 2'd0, 0, 0); // R3 readback
      // R5 R6 R7 stack pointer, aligned, privileged
      do_op(16'h000F, 5'd1, 5'd31, 64'h5, 64'h40, 0, 0, 2'd1, 0, 0);
      // R5 R8 misaligned stack pointer: fault, no access
      do_op(16'hFFFF, 5'd1, 5'd31, 64'h0, 64'h48, 0, 0, 2'd3, 0, 0);
      do_op(16'h0000, 5'd2, 5'd5, 64'h48, 64'h0, 0, 0, 2'd0, 0, 0); // R8 memory intact
      // R8 odd halfword address via base register
      do_op(16'hFFFF, 5'd2, 5'd5, 64'h51, 64'h0, 0, 0, 2'd0, 0, 0);
      do_op(16'h0000, 5'd2, 5'd5, 64'h50, 64'h0, 0, 0, 2'd0, 0, 0); // R8 memory intact
      // R9 R10 memory stalls while locked
      do_op(16'h0F0F, 5'd4, 5'd3, 64'h60, 64'h0, 1, 1, 2'd1, 1, 4);
      do_op(16'h0000, 5'd4, 5'd3, 64'h60, 64'h0, 0, 0, 2'd0, 0, 0);
      // R12 constant-time: latency independent of data
      do_op(16'hFFFF, 5'd5, 5'd3, 64'h70, 64'h0, 0, 0, 2'd0, 1, 0);
      lat_a = last_lat;
      do_op(16'h0000, 5'd5, 5'd3, 64'h72, 64'h0, 0, 0, 2'd0, 1, 0);
      chk(last_lat == lat_a, "R12 latency data independent", 64'(last_lat), 64'(lat_a));

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule